// File: doc/BRIEF.md
# Quad-Rate Burst SRAM Core

This block is a synthesizable model of a burst-of-four static memory with a separate read data path and write data path. The external clock pair is modelled as the two phases of one fast clock, `clk_i`. Fast edges alternate between "K" edges and "K#" edges, and the phase flag `k_phase_o` is high when the next rising edge is a K edge. Commands are taken only on K edges: an active-low read select, an active-low write select and a shared word address.

A write moves four words. They are taken from `d_i` on the four fast edges that begin two edges after the command. Each beat carries its own two-bit active-low half-word enable. A read returns four words on `q_o`, beginning five fast edges after the command, which is two and a half K cycles. Between bursts the output is parked at zero with `q_valid_o` low, which stands in for a tristated bus. Issuing the same kind of request on two consecutive K edges is not allowed, and the block drops the second one.

Top module: `qrb_sram`

## Requirements
- R1: After reset `k_phase_o` is 1 and it toggles on every `clk_i` edge. Selects and address are sampled only on edges taken while `k_phase_o` is 1 (K edges), so a select asserted only on a K# edge starts nothing.
- R2: On a K edge, `rd_sel_ni`=0 starts a read. `wr_sel_ni`=0 together with `rd_sel_ni`=1 starts a write. When both are 0, only the read starts.
- R3: A burst addresses four words. Bits [AW-1:2] are the latched address and bits [1:0] are the latched low bits plus 0, 1, 2 and 3, modulo 4.
- R4: For a write started on fast edge E, beat i (i=0..3) is taken from `d_i`/`wmask_ni` on edge E+2+i.
- R5: For a read started on edge E, beat i is driven on `q_o` by edge E+5+i. `q_valid_o` is 1 exactly after those four edges, and beat 0 always follows a K# edge.
- R6: A request is ignored if its own select was 0 on the previous K edge, whether or not that earlier request was accepted.
- R7: `wmask_ni[0]`=0 writes bits [DW/2-1:0] and `wmask_ni[1]`=0 writes bits [DW-1:DW/2]. A half whose bit is 1 keeps its contents. The mask may differ on every beat.
- R8: Whenever no read beat is driven, including during and after reset, `q_valid_o` is 0 and `q_o` is all zeros.
- R9: Read and write bursts may overlap. A read beat returns the word held in the array before any write beat taken on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock; its edges alternate between K and K# |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_sel_ni | input | 1 | Read request, active low, sampled on K edges |
| wr_sel_ni | input | 1 | Write request, active low, sampled on K edges |
| addr_i | input | AW | Burst start address |
| d_i | input | DW | Write data beat |
| wmask_ni | input | 2 | Per-beat half-word write enables, active low |
| k_phase_o | output | 1 | High when the next edge is a K edge |
| q_o | output | DW | Read data beat, zero when idle |
| q_valid_o | output | 1 | High on the four read beat phases |

## Verification
The bench uses the default AW=6 and DW=8. This gives a 64-word array that the fill phase covers completely, so every later read has a known expected value, and random traffic reaches every wrap position inside a burst. The 4-bit halves let random per-beat masks produce every mix of kept and replaced halves. The cases where a read beat lands on the same edge as a write beat to the same word occur often at this size.

// File: rtl/qrb_pkg.sv
package qrb_pkg;
  localparam int unsigned NBEAT  = 4;
  localparam int unsigned WR_LAT = 2;  // fast edges from command to first write beat
  localparam int unsigned RD_LAT = 5;  // fast edges from command to first read beat

  function automatic logic [1:0] wrap_low(input logic [1:0] base, input logic [1:0] beat);
    return base + beat;
  endfunction
endpackage

// File: rtl/qrb_cmd.sv
module qrb_cmd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic k_edge_i,
  input  logic rd_sel_ni,
  input  logic wr_sel_ni,
  output logic rd_go_o,
  output logic wr_go_o
);
  logic prev_rd_n_q, prev_wr_n_q;

  // raw previous-K sample, independent of acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_rd_n_q <= 1'b1;
      prev_wr_n_q <= 1'b1;
    end else if (k_edge_i) begin
      prev_rd_n_q <= rd_sel_ni;
      prev_wr_n_q <= wr_sel_ni;
    end
  end

  always_comb begin
    rd_go_o = k_edge_i && !rd_sel_ni && prev_rd_n_q;
    wr_go_o = k_edge_i && !wr_sel_ni && rd_sel_ni && prev_wr_n_q;
  end
endmodule

// File: rtl/qrb_dly.sv
module qrb_dly #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned AW    = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_v_i,
  input  logic [AW-1:0] in_a_i,
  output logic          out_v_o,
  output logic [AW-1:0] out_a_o
);
  logic [DEPTH-1:0] v_q;
  logic [AW-1:0]    a_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[0] <= 1'b0;
          a_q[0] <= '0;
        end else begin
          v_q[0] <= in_v_i;
          a_q[0] <= in_a_i;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[i] <= 1'b0;
          a_q[i] <= '0;
        end else begin
          v_q[i] <= v_q[i-1];
          a_q[i] <= a_q[i-1];
        end
      end
    end
  end

  assign out_v_o = v_q[DEPTH-1];
  assign out_a_o = a_q[DEPTH-1];
endmodule

// File: rtl/qrb_burst.sv
module qrb_burst
  import qrb_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_a_i,
  output logic          act_o,
  output logic [AW-1:0] addr_o
);
  logic [1:0]    cnt_q;
  logic          busy_q;
  logic [AW-1:0] base_q;
  logic [AW-1:0] base;
  logic [1:0]    beat;

  always_comb begin
    base   = start_i ? start_a_i : base_q;
    beat   = start_i ? 2'd0 : cnt_q;
    act_o  = start_i || busy_q;
    addr_o = {base[AW-1:2], wrap_low(base[1:0], beat)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      base_q <= '0;
    end else if (start_i) begin
      cnt_q  <= 2'd1;
      busy_q <= 1'b1;
      base_q <= start_a_i;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 2'd1;
      if (cnt_q == 2'(NBEAT - 1)) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/qrb_mem.sv
module qrb_mem #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic [1:0]    we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned HW    = DW / 2;
  localparam int unsigned WORDS = 1 << AW;

  logic [DW-1:0] mem_q [WORDS];

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk_i) begin
      if (we_i[h]) mem_q[waddr_i][h*HW +: HW] <= wdata_i[h*HW +: HW];
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/qrb_sram.sv
module qrb_sram
  import qrb_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_sel_ni,
  input  logic          wr_sel_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] d_i,
  input  logic [1:0]    wmask_ni,
  output logic          k_phase_o,
  output logic [DW-1:0] q_o,
  output logic          q_valid_o
);
  logic          k_phase_q;
  logic          rd_go, wr_go;
  logic          wst_v, rst_v;
  logic [AW-1:0] wst_a, rst_a;
  logic          wact, ract;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] rdata;
  logic [DW-1:0] q_q;
  logic          qv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) k_phase_q <= 1'b1;
    else         k_phase_q <= !k_phase_q;
  end

  qrb_cmd u_cmd (
    .clk_i, .rst_ni,
    .k_edge_i (k_phase_q),
    .rd_sel_ni, .wr_sel_ni,
    .rd_go_o  (rd_go),
    .wr_go_o  (wr_go)
  );

  qrb_dly #(.DEPTH(WR_LAT), .AW(AW)) u_wdly (
    .clk_i, .rst_ni,
    .in_v_i (wr_go), .in_a_i (addr_i),
    .out_v_o(wst_v), .out_a_o(wst_a)
  );

  qrb_dly #(.DEPTH(RD_LAT), .AW(AW)) u_rdly (
    .clk_i, .rst_ni,
    .in_v_i (rd_go), .in_a_i (addr_i),
    .out_v_o(rst_v), .out_a_o(rst_a)
  );

  qrb_burst #(.AW(AW)) u_wseq (
    .clk_i, .rst_ni,
    .start_i(wst_v), .start_a_i(wst_a),
    .act_o  (wact),  .addr_o   (waddr)
  );

  qrb_burst #(.AW(AW)) u_rseq (
    .clk_i, .rst_ni,
    .start_i(rst_v), .start_a_i(rst_a),
    .act_o  (ract),  .addr_o   (raddr)
  );

  qrb_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i,
    .we_i   ({2{wact}} & ~wmask_ni),
    .waddr_i(waddr),
    .wdata_i(d_i),
    .raddr_i(raddr),
    .rdata_o(rdata)
  );

  // array read is the pre-edge value, so a same-edge write is not seen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q  <= '0;
      qv_q <= 1'b0;
    end else begin
      q_q  <= ract ? rdata : '0;
      qv_q <= ract;
    end
  end

  assign k_phase_o = k_phase_q;
  assign q_o       = q_q;
  assign q_valid_o = qv_q;
endmodule

// File: rtl/qrb_sram_chk.sv
module qrb_sram_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          k_phase_o,
  input logic          q_valid_o,
  input logic [DW-1:0] q_o,
  input logic          rd_go,
  input logic          wr_go
);
  a_r10_phase_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> k_phase_o != $past(k_phase_o));

  a_r1_cmd_on_k: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_go || wr_go) |-> k_phase_o);

  a_r2_read_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_go && wr_go));

  a_r6_rd_lockout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_go |=> ##1 !rd_go);

  a_r6_wr_lockout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_go |=> ##1 !wr_go);

  a_r5_four_beats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_valid_o) |-> q_valid_o ##1 q_valid_o ##1 q_valid_o ##1 q_valid_o);

  a_r5_first_after_kbar: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_valid_o) |-> k_phase_o);

  a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_valid_o |-> q_o == '0);
endmodule

bind qrb_sram qrb_sram_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .k_phase_o(k_phase_o),
  .q_valid_o(q_valid_o),
  .q_o      (q_o),
  .rd_go    (rd_go),
  .wr_go    (wr_go)
);

// File: tb/tb_qrb_sram.sv
module tb_qrb_sram;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int HW = DW / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d = '0;
  logic [1:0]    wm = 2'b00;
  logic          kph, qv;
  logic [DW-1:0] q;

  int checks = 0, errors = 0;
  int mask_mode = 0;
  string cur_req = "R8 R10";

  always #4 clk = ~clk;

  qrb_sram #(.AW(AW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_sel_ni(rd_n), .wr_sel_ni(wr_n),
    .addr_i(addr), .d_i(d), .wmask_ni(wm),
    .k_phase_o(kph), .q_o(q), .q_valid_o(qv)
  );

  // reference model
  logic [DW-1:0] mm [1<<AW];
  logic          rdv [16];
  logic [AW-1:0] rda [16];
  logic          wrv [16];
  logic [AW-1:0] wra [16];
  int            n = 0;
  logic          kf = 1'b1, prd = 1'b1, pwr = 1'b1;
  logic          ev = 1'b0;
  logic [DW-1:0] eq = '0;

  initial for (int i = 0; i < 16; i++) begin rdv[i] = 0; wrv[i] = 0; rda[i] = 0; wra[i] = 0; end

  function automatic logic [AW-1:0] bad(input logic [AW-1:0] a, input int i);
    return {a[AW-1:2], 2'(a[1:0] + i)};
  endfunction

  always @(posedge clk) if (rst_n) begin
    int s;
    s = n % 16;
    ev = rdv[s];
    eq = rdv[s] ? mm[rda[s]] : '0;
    rdv[s] = 0;
    if (wrv[s]) begin
      if (!wm[0]) mm[wra[s]][HW-1:0]  = d[HW-1:0];
      if (!wm[1]) mm[wra[s]][DW-1:HW] = d[DW-1:HW];
      wrv[s] = 0;
    end
    if (kf) begin
      if (!rd_n && prd)
        for (int i = 0; i < 4; i++) begin rdv[(n+5+i)%16] = 1; rda[(n+5+i)%16] = bad(addr, i); end
      else if (!wr_n && rd_n && pwr)
        for (int i = 0; i < 4; i++) begin wrv[(n+2+i)%16] = 1; wra[(n+2+i)%16] = bad(addr, i); end
      prd = rd_n;
      pwr = wr_n;
    end
    kf = !kf;
    n++;
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    checks++;
    if (!rst_n) begin
      if (qv !== 1'b0 || q !== '0 || kph !== 1'b1) begin
        errors++;
        $display("FAIL R8 R1 reset: qv=%b q=%h kph=%b exp qv=0 q=0 kph=1", qv, q, kph);
      end
    end else if (qv !== ev || q !== eq || kph !== kf) begin
      errors++;
      $display("FAIL %s edge %0d: qv=%b q=%h kph=%b exp qv=%b q=%h kph=%b",
               cur_req, n, qv, q, kph, ev, eq, kf);
    end
  end

  // data and mask driver
  always @(negedge clk) begin
    d  <= DW'($urandom);
    wm <= (mask_mode == 0) ? 2'b00 : 2'($urandom);
  end

  task automatic go_k();
    @(negedge clk);
    while (kph !== 1'b1) @(negedge clk);
  endtask

  task automatic issue(input logic r, input logic w, input logic [AW-1:0] a);
    go_k();
    rd_n = r; wr_n = w; addr = a;
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1; addr = AW'($urandom);
  endtask

  task automatic idle(input int c);
    for (int i = 0; i < c; i++) issue(1'b1, 1'b1, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R4 R3";                      // fill whole array
    for (int a = 0; a < (1 << AW); a += 4) begin issue(1, 0, AW'(a)); idle(1); end
    idle(3);

    cur_req = "R5 R3";                      // aligned and wrapping reads
    issue(0, 1, 6'd0);  idle(3);
    issue(0, 1, 6'd6);  idle(3);
    issue(0, 1, 6'd63); idle(3);
    issue(0, 1, 6'd17); idle(1);

    cur_req = "R6";                         // back-to-back and held selects
    issue(0, 1, 6'd8); issue(0, 1, 6'd12); idle(3);
    issue(1, 0, 6'd20); issue(1, 0, 6'd24); idle(3);
    issue(0, 1, 6'd24); issue(0, 1, 6'd28); issue(0, 1, 6'd32); idle(4);
    issue(0, 1, 6'd20); idle(3);

    cur_req = "R2";                         // both selects low: read only
    issue(0, 0, 6'd40); idle(3);
    issue(0, 1, 6'd40); idle(3);

    cur_req = "R1";                         // selects only on K# edge
    go_k(); @(negedge clk);
    rd_n = 0; wr_n = 0; addr = 6'd44;
    @(negedge clk); rd_n = 1; wr_n = 1;
    idle(4);

    cur_req = "R7";                         // random per-beat half masks
    mask_mode = 1;
    for (int i = 0; i < 8; i++) begin issue(1, 0, AW'(i * 5)); idle(1); end
    mask_mode = 0;
    for (int i = 0; i < 8; i++) begin issue(0, 1, AW'(i * 5)); idle(1); end
    idle(3);

    cur_req = "R9";                         // overlapping read/write, same words
    mask_mode = 1;
    issue(0, 1, 6'd48); issue(1, 0, 6'd48); idle(4);
    issue(1, 0, 6'd52); issue(0, 1, 6'd52); idle(4);
    issue(0, 1, 6'd49); idle(1); issue(1, 0, 6'd50); idle(4);

    cur_req = "R2 R5 R6 R9";                // random traffic
    for (int i = 0; i < 400; i++)
      issue(($urandom % 3) == 0 ? 1'b1 : 1'b0, ($urandom % 3) == 0 ? 1'b1 : 1'b0, AW'($urandom));
    cur_req = "R8 R10";
    idle(6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule